// File: doc/BRIEF.md
# Keyed-Write Watchdog Timer

An 8-bit up-counting watchdog and interval timer that sits on a 16-bit peripheral register bus. It exposes two registers: the count value and a control/status register with the run enable, a sticky overflow flag and a 3-bit prescaler select. A write only lands when it is a 16-bit transfer and its upper byte carries the 8-bit key that belongs to the target register. The lower byte is then the new register value. Any other write is dropped without trace.

While enabled, the counter advances on a one-cycle strobe taken from a 12-bit divider that runs on the peripheral clock. When the counter rolls over from all ones to zero, the block sets the overflow flag and drives a single-cycle overflow pulse. System code clears the flag with a keyed control write. To keep the prescaler consistent, the select bits are frozen while the timer runs.

Top module: `keyed_wdog`

## Requirements
- R1: Only word transfers (bus_size 2'b01) can write. Byte (2'b00) and 32-bit (2'b10) writes to either register change nothing.
- R2: A word write to offset 0x84 whose bits [15:8] equal 0x5A loads bits [7:0] into the counter at the next clock edge.
- R3: A word write to offset 0x86 whose bits [15:8] equal 0xA5 loads the control/status register at the next edge. Bit 7 is enable, bit 6 is the overflow flag, bits [5:3] are stored as written, and bits [2:0] are the clock select.
- R4: A word write whose upper byte does not match the key of the addressed register changes neither register.
- R5: Select codes 0 to 7 give one count every 1, 4, 16, 32, 64, 256, 1024 and 4096 clocks. The first count lands exactly one period after the edge that sets enable.
- R6: While enable is 1, a control write leaves bits [2:0] unchanged. This holds even for the write that clears enable.
- R7: While enable is 0, the counter holds its value and the divider restarts from zero.
- R8: A count from 0xFF to 0x00 sets the flag and raises ovf_pulse for exactly one cycle, in the cycle that the counter reads 0x00.
- R9: The flag clears only through a keyed control write with bit 6 at 0. Writing 1 keeps the flag as it is. When a rollover and a clearing write meet in the same cycle, the flag ends up set.
- R10: A read (bus_sel=1, bus_wr=0) of 0x84 or 0x86 returns the register value in bits [7:0] and zero in bits [15:8], with no key. Any other address, and any cycle that is not a read, returns zero.
- R11: A keyed counter write in a cycle where a count is due loads the written value, and that cycle produces no rollover.
- R12: After reset, both registers read zero and ovf_pulse is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Transfer valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_size | input | 2 | 00 byte, 01 word, 10 32-bit |
| bus_addr | input | 8 | Register offset within the page |
| bus_wdata | input | 16 | Write data: key in [15:8], value in [7:0] |
| bus_rdata | output | 16 | Read data, combinational |
| ovf_pulse | output | 1 | One-cycle rollover pulse |

## Verification
The sharpest collision is a rollover that falls in the same cycle as a control write that clears the flag. The bench provokes it by loading 0xFF with the divide-by-1 select, then issuing the enabling write and a flag-clearing write on back-to-back cycles. A read of the control register must then show the flag set. The second collision is a counter write that coincides with a due count at 0xFF. The bench repeats a load of 0xFF on consecutive cycles and expects the loaded value with no pulse. A behavioural model that steps every clock judges both cases alongside the directed reads.

// File: rtl/keyed_wdog_pkg.sv
package keyed_wdog_pkg;

   typedef enum logic [1:0] {
      XFER_BYTE = 2'b00,
      XFER_WORD = 2'b01,
      XFER_LONG = 2'b10
   } xfer_e;

   localparam int NUM_SEL   = 8;
   localparam int SEL_W     = $clog2(NUM_SEL);
   localparam int MAX_SHIFT = 12;

   // log2 of the division ratio selected by each clock-select code
   function automatic int sel_shift(input int code);
      case (code)
         0:       return 0;
         1:       return 2;
         2:       return 4;
         3:       return 5;
         4:       return 6;
         5:       return 8;
         6:       return 10;
         default: return 12;
      endcase
   endfunction

endpackage

// File: rtl/kwd_decode.sv
module kwd_decode
   import keyed_wdog_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 16,
   parameter logic [ADDR_W-1:0] CNT_ADDR = 8'h84,
   parameter logic [ADDR_W-1:0] CSR_ADDR = 8'h86,
   parameter logic [DATA_W/2-1:0] CNT_KEY = 8'h5A,
   parameter logic [DATA_W/2-1:0] CSR_KEY = 8'hA5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [1:0]        bus_size,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic              cnt_we,
   output logic              csr_we,
   output logic [DATA_W/2-1:0] wr_val
);
   localparam int KEY_W = DATA_W / 2;

   logic             word_wr;
   logic [KEY_W-1:0] key;

   assign key     = bus_wdata[DATA_W-1:KEY_W];
   assign wr_val  = bus_wdata[KEY_W-1:0];
   assign word_wr = bus_sel & bus_wr & (bus_size == XFER_WORD);
   assign cnt_we  = word_wr & (bus_addr == CNT_ADDR) & (key == CNT_KEY);
   assign csr_we  = word_wr & (bus_addr == CSR_ADDR) & (key == CSR_KEY);

   // R1: non-word transfers never produce a register write strobe
   a_r1_word_only: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_size != XFER_WORD) |-> !(cnt_we || csr_we));

   // R4: the two strobes never fire together
   a_r4_one_target: assert property (@(posedge clk) disable iff (!rst_n)
      !(cnt_we && csr_we));

endmodule

// File: rtl/kwd_prescale.sv
module kwd_prescale
   import keyed_wdog_pkg::*;
#(
   parameter int DIV_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [SEL_W-1:0] cksel,
   output logic             tick
);
   logic [DIV_W-1:0]   div_q;
   logic [NUM_SEL-1:0] hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    div_q <= '0;
      else if (!run) div_q <= '0;
      else           div_q <= div_q + 1'b1;
   end

   // one tap per select code: fires when the low bits of the divider are all ones
   for (genvar g = 0; g < NUM_SEL; g++) begin : g_tap
      localparam int SH = sel_shift(g);
      if (SH == 0) begin : g_direct
         assign hit[g] = 1'b1;
      end else begin : g_masked
         assign hit[g] = &div_q[SH-1:0];
      end
   end

   assign tick = run & hit[cksel];

   // R7: the divider restarts from zero after every idle cycle
   a_r7_div_restart: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (div_q == '0));

endmodule

// File: rtl/kwd_core.sv
module kwd_core
   import keyed_wdog_pkg::*;
#(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cnt_we,
   input  logic             csr_we,
   input  logic [CNT_W-1:0] wr_val,
   input  logic             tick,
   output logic [CNT_W-1:0] cnt_q,
   output logic [CNT_W-1:0] csr_q,
   output logic             run,
   output logic [SEL_W-1:0] cksel,
   output logic             ovf_pulse
);
   localparam int EN_BIT   = CNT_W - 1;
   localparam int FLAG_BIT = CNT_W - 2;

   logic             wrap;
   logic [CNT_W-1:0] csr_nx;

   assign run   = csr_q[EN_BIT];
   assign cksel = csr_q[SEL_W-1:0];
   assign wrap  = tick & ~cnt_we & (cnt_q == '1);

   always_comb begin
      csr_nx = csr_q;
      if (csr_we) begin
         csr_nx = wr_val;
         csr_nx[FLAG_BIT] = csr_q[FLAG_BIT] & wr_val[FLAG_BIT];
         if (csr_q[EN_BIT]) csr_nx[SEL_W-1:0] = csr_q[SEL_W-1:0];
      end
      if (wrap) csr_nx[FLAG_BIT] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q     <= '0;
         csr_q     <= '0;
         ovf_pulse <= 1'b0;
      end else begin
         if (cnt_we)    cnt_q <= wr_val;
         else if (tick) cnt_q <= cnt_q + 1'b1;
         csr_q     <= csr_nx;
         ovf_pulse <= wrap;
      end
   end

   // R8: the overflow pulse lasts a single cycle
   a_r8_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_pulse |=> !ovf_pulse);

   // R8: the flag is up whenever the pulse is
   a_r8_flag_with_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_pulse |-> csr_q[FLAG_BIT]);

   // R7: an idle counter holds unless it is written
   a_r7_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !cnt_we) |=> (cnt_q == $past(cnt_q)));

   // R7: no count strobe arrives while disabled
   a_r7_no_tick_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !run |-> !tick);

   // R6: the select field is frozen while running
   a_r6_sel_locked: assert property (@(posedge clk) disable iff (!rst_n)
      run |=> (cksel == $past(cksel)));

   // R2: an accepted counter write lands next cycle
   a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_we |=> (cnt_q == $past(wr_val)));

endmodule

// File: rtl/keyed_wdog.sv
module keyed_wdog
   import keyed_wdog_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 16,
   parameter int DIV_W  = 12,
   parameter logic [ADDR_W-1:0] CNT_ADDR = 8'h84,
   parameter logic [ADDR_W-1:0] CSR_ADDR = 8'h86,
   parameter logic [DATA_W/2-1:0] CNT_KEY = 8'h5A,
   parameter logic [DATA_W/2-1:0] CSR_KEY = 8'hA5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [1:0]        bus_size,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              ovf_pulse
);
   localparam int KEY_W = DATA_W / 2;
   localparam int CNT_W = KEY_W;
   localparam int PAD_W = DATA_W - CNT_W;

   if (DATA_W % 2 != 0) begin : g_chk_even
      $error("keyed_wdog: DATA_W must be even");
   end
   if (CNT_W < SEL_W + 2) begin : g_chk_cnt
      $error("keyed_wdog: register too narrow for enable, flag and select");
   end
   if (DIV_W < MAX_SHIFT) begin : g_chk_div
      $error("keyed_wdog: DIV_W too small for the largest ratio");
   end
   if (CNT_ADDR == CSR_ADDR) begin : g_chk_addr
      $error("keyed_wdog: register offsets must differ");
   end

   logic             cnt_we, csr_we, run, tick;
   logic [CNT_W-1:0] wr_val, cnt_q, csr_q;
   logic [SEL_W-1:0] cksel;
   logic             rd;

   kwd_decode #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W),
      .CNT_ADDR(CNT_ADDR), .CSR_ADDR(CSR_ADDR),
      .CNT_KEY(CNT_KEY), .CSR_KEY(CSR_KEY)
   ) i_decode (
      .clk(clk), .rst_n(rst_n),
      .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_size(bus_size),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .cnt_we(cnt_we), .csr_we(csr_we), .wr_val(wr_val)
   );

   kwd_prescale #(.DIV_W(DIV_W)) i_prescale (
      .clk(clk), .rst_n(rst_n), .run(run), .cksel(cksel), .tick(tick)
   );

   kwd_core #(.CNT_W(CNT_W)) i_core (
      .clk(clk), .rst_n(rst_n),
      .cnt_we(cnt_we), .csr_we(csr_we), .wr_val(wr_val), .tick(tick),
      .cnt_q(cnt_q), .csr_q(csr_q), .run(run), .cksel(cksel),
      .ovf_pulse(ovf_pulse)
   );

   assign rd = bus_sel & ~bus_wr;

   always_comb begin
      bus_rdata = '0;
      if (rd && bus_addr == CNT_ADDR)      bus_rdata = {{PAD_W{1'b0}}, cnt_q};
      else if (rd && bus_addr == CSR_ADDR) bus_rdata = {{PAD_W{1'b0}}, csr_q};
   end

   // R10: the upper half of read data is always zero
   a_r10_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rdata[DATA_W-1:CNT_W] == '0);

endmodule

// File: tb/test_keyed_wdog.sv
module test_keyed_wdog;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0, bus_wr = 1'b0;
   logic [1:0]  bus_size = 2'b01;
   logic [7:0]  bus_addr = 8'h00;
   logic [15:0] bus_wdata = 16'h0000;
   logic [15:0] bus_rdata;
   logic        ovf_pulse;

   int n_chk = 0, n_fail = 0, pulses = 0;
   string cur_req = "R12";

   // reference model state
   logic [7:0] m_cnt = 0, m_csr = 0;
   int         m_div = 0;
   logic       m_pulse = 0;
   int         m_r;
   bit         m_tk, m_wc, m_ws, m_wrp;

   always #(CLK_PERIOD/2) clk = ~clk;

   keyed_wdog i_keyed_wdog (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_size(bus_size), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .ovf_pulse(ovf_pulse)
   );

   function automatic int ratio(input logic [2:0] c);
      case (c)
         3'd0: return 1;    3'd1: return 4;    3'd2: return 16;  3'd3: return 32;
         3'd4: return 64;   3'd5: return 256;  3'd6: return 1024;
         default: return 4096;
      endcase
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cnt = 0; m_csr = 0; m_div = 0; m_pulse = 0;
      end else begin
         m_wc  = bus_sel && bus_wr && bus_size == 2'b01 && bus_addr == 8'h84 && bus_wdata[15:8] == 8'h5A;
         m_ws  = bus_sel && bus_wr && bus_size == 2'b01 && bus_addr == 8'h86 && bus_wdata[15:8] == 8'hA5;
         m_r   = ratio(m_csr[2:0]);
         m_tk  = m_csr[7] && (m_div % m_r == m_r - 1);
         m_wrp = m_tk && !m_wc && m_cnt == 8'hFF;
         m_pulse = m_wrp;
         m_div = m_csr[7] ? (m_div + 1) % 4096 : 0;
         if (m_wc) m_cnt = bus_wdata[7:0];
         else if (m_tk) m_cnt = m_cnt + 8'd1;
         if (m_ws)
            m_csr = {bus_wdata[7], m_csr[6] & bus_wdata[6], bus_wdata[5:3],
                     m_csr[7] ? m_csr[2:0] : bus_wdata[2:0]};
         if (m_wrp) m_csr[6] = 1'b1;
      end
   end

   function automatic logic [15:0] model_rdata();
      if (bus_sel && !bus_wr && bus_addr == 8'h84) return {8'h00, m_cnt};
      if (bus_sel && !bus_wr && bus_addr == 8'h86) return {8'h00, m_csr};
      return 16'h0000;
   endfunction

   task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // one clock: compare against the model at the falling edge
   task automatic step();
      @(negedge clk);
      chk(cur_req, "model rdata", bus_rdata, model_rdata());
      chk(cur_req, "model pulse", {15'd0, ovf_pulse}, {15'd0, m_pulse});
      if (ovf_pulse) pulses++;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step();
   endtask

   task automatic wr(input logic [7:0] a, input logic [1:0] sz, input logic [15:0] d);
      bus_sel = 1; bus_wr = 1; bus_size = sz; bus_addr = a; bus_wdata = d;
      step();
      bus_sel = 0; bus_wr = 0; bus_size = 2'b01;
   endtask

   task automatic rd(input logic [7:0] a, input logic [15:0] exp, input string req);
      bus_sel = 1; bus_wr = 0; bus_addr = a;
      step();
      chk(req, "read", bus_rdata, exp);
      bus_sel = 0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL R12 watchdog: actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R12 reset state
      chk("R12", "pulse after reset", {15'd0, ovf_pulse}, 16'd0);
      rd(8'h84, 16'h0000, "R12");
      rd(8'h86, 16'h0000, "R12");

      cur_req = "R2";
      wr(8'h84, 2'b01, 16'h5A3C);
      rd(8'h84, 16'h003C, "R2");

      cur_req = "R1";
      wr(8'h84, 2'b00, 16'h5A11);
      rd(8'h84, 16'h003C, "R1");
      wr(8'h84, 2'b10, 16'h5A22);
      rd(8'h84, 16'h003C, "R1");
      wr(8'h86, 2'b00, 16'hA583);
      rd(8'h86, 16'h0000, "R1");

      cur_req = "R4";
      wr(8'h84, 2'b01, 16'hA577);
      rd(8'h84, 16'h003C, "R4");
      wr(8'h86, 2'b01, 16'h5A81);
      rd(8'h86, 16'h0000, "R4");

      cur_req = "R3";
      wr(8'h86, 2'b01, 16'hA539);
      rd(8'h86, 16'h0039, "R3");
      wr(8'h86, 2'b01, 16'hA501);
      rd(8'h86, 16'h0001, "R3");

      cur_req = "R7";
      idle(20);
      rd(8'h84, 16'h003C, "R7");
      wr(8'h86, 2'b01, 16'hA581);
      bus_sel = 1; bus_addr = 8'h84;
      idle(30);
      bus_sel = 0;

      cur_req = "R6";
      wr(8'h86, 2'b01, 16'hA587);
      rd(8'h86, 16'h0081, "R6");

      cur_req = "R8";
      wr(8'h84, 2'b01, 16'h5AFC);
      pulses = 0;
      idle(40);
      chk("R8", "pulse count", 16'(pulses), 16'd1);
      rd(8'h86, 16'h00C1, "R8");

      cur_req = "R9";
      wr(8'h86, 2'b01, 16'hA5C1);
      rd(8'h86, 16'h00C1, "R9");
      wr(8'h86, 2'b01, 16'hA581);
      rd(8'h86, 16'h0081, "R9");
      // disabling write keeps select at code 1 (R6)
      wr(8'h86, 2'b01, 16'hA500);
      rd(8'h86, 16'h0001, "R6");
      wr(8'h86, 2'b01, 16'hA500);
      rd(8'h86, 16'h0000, "R9");
      // rollover meets a flag-clearing write in the same cycle
      wr(8'h84, 2'b01, 16'h5AFF);
      wr(8'h86, 2'b01, 16'hA580);
      wr(8'h86, 2'b01, 16'hA580);
      rd(8'h86, 16'h00C0, "R9");

      cur_req = "R11";
      wr(8'h86, 2'b01, 16'hA580);
      rd(8'h86, 16'h0080, "R11");
      pulses = 0;
      wr(8'h84, 2'b01, 16'h5AFF);
      wr(8'h84, 2'b01, 16'h5AFF);
      wr(8'h84, 2'b01, 16'h5A50);
      rd(8'h84, 16'h0051, "R11");
      chk("R11", "no pulse on written count", 16'(pulses), 16'd0);
      rd(8'h86, 16'h0080, "R11");

      cur_req = "R10";
      rd(8'h88, 16'h0000, "R10");
      bus_sel = 1; bus_wr = 1; bus_size = 2'b01; bus_addr = 8'h86; bus_wdata = 16'h1234;
      step();
      chk("R10", "rdata during write", bus_rdata, 16'h0000);
      bus_sel = 0; bus_wr = 0;

      cur_req = "R5";
      wr(8'h86, 2'b01, 16'hA500);
      for (int c = 0; c < 8; c++) begin
         int r;
         r = ratio(3'(c));
         wr(8'h86, 2'b01, 16'hA500 | 16'(c));
         wr(8'h84, 2'b01, 16'h5A00);
         wr(8'h86, 2'b01, 16'hA580 | 16'(c));
         idle(3 * r - 2);
         rd(8'h84, 16'h0002, "R5");
         rd(8'h84, 16'h0003, "R5");
         wr(8'h86, 2'b01, 16'hA500);
      end

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule